// File: doc/BRIEF.md
# IO Register File with Bit-Manipulation Port

This block holds a bank of 8-bit IO registers behind a single general access port. A 3-bit opcode chooses what the port does in a cycle. It can write a byte, read a byte, clear or set one bit, copy one bit of the data input into the status T flag, or return the data input with one bit replaced by the T flag. The register address is 6 bits wide, which gives 64 locations. A 3-bit index picks the bit for the bit operations.

A clear or set is a read-modify-write. The caller first reads the register, then presents that value on the data input together with the bit index, and the block stores the modified byte. A small group of kernel registers also has dedicated write ports, so a pipeline can update them without going through the general port. These are the status register, the two stack-pointer bytes and the address-extension registers. Their contents are always visible on outputs. Dedicated slot k maps to general address 63-k, so slot 0 is the status register at address 63.

Top module: `ioreg_bitport`

## Requirements
- R1: Asserting the asynchronous reset (`rst_n` low), or the synchronous reset (`srst` high at a clock edge), sets all 64 registers to zero.
- R2: Opcode 1 (write byte) stores `din` into the register at `addr` at the clock edge.
- R3: Opcode 2 (read byte) puts the register at `addr` on `dout` in the same cycle. For every opcode other than 2 and 6, `dout` is zero.
- R4: Opcode 3 (clear bit) stores `din` with bit `bidx` forced to 0 into the register at `addr`.
- R5: Opcode 4 (set bit) stores `din` with bit `bidx` forced to 1 into the register at `addr`.
- R6: Opcode 5 (store bit) copies `din[bidx]` into the T flag, which is bit 6 of the status register at address 63. The other status bits are left unchanged.
- R7: Opcode 6 (load bit) drives `dout` with `din`, except that bit `bidx` is replaced by the current T flag. No register changes.
- R8: When `ded_we[k]` is high, `ded_di[8k+7:8k]` is stored into the register at address 63-k. `ded_q[8k+7:8k]` always shows that register, and `stat_o` always shows address 63.
- R9: When a dedicated write and a general-port write (opcodes 1, 3, 4 or 5) hit the same register in one cycle, the dedicated data is stored.
- R10: `bit_o` always shows bit `bidx` of the register at `addr`.
- R11: Opcodes 0 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| op | input | 3 | General-port opcode |
| addr | input | 6 | Register address |
| bidx | input | 3 | Bit index |
| din | input | 8 | General-port data in |
| dout | output | 8 | General-port data out |
| bit_o | output | 1 | Selected bit of the addressed register |
| stat_o | output | 8 | Status register (address 63) |
| ded_we | input | 8 | Dedicated write enables, one per slot |
| ded_di | input | 64 | Dedicated write data, 8 bits per slot |
| ded_q | output | 64 | Dedicated register contents, 8 bits per slot |

## Verification
The cycle that matters most is the one where a dedicated-port write and a general-port write land on the same register. The store-bit opcode counts as a general-port write, because it rewrites the status register. The random stimulus biases general addresses toward the eight dedicated locations, raises dedicated enables at random, and issues store-bit often, so these collisions happen many times. Each one is judged against a bench model that applies the general write first and the dedicated write after it, then compares every dedicated output and later read-backs of the same register.

// File: rtl/ioreg_bitport.sv
module ioreg_bitport #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int NDED   = 8,
  parameter int TBIT   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   srst,
  input  logic [2:0]             op,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [$clog2(DATA_W)-1:0] bidx,
  input  logic [DATA_W-1:0]      din,
  output logic [DATA_W-1:0]      dout,
  output logic                   bit_o,
  output logic [DATA_W-1:0]      stat_o,
  input  logic [NDED-1:0]        ded_we,
  input  logic [NDED*DATA_W-1:0] ded_di,
  output logic [NDED*DATA_W-1:0] ded_q
);
  localparam int NREG = 1 << ADDR_W;
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] STAT = ADDR_W'(NREG - 1);
  localparam logic [2:0] OP_WR = 3'd1, OP_RD = 3'd2, OP_CLR = 3'd3,
                         OP_SET = 3'd4, OP_STB = 3'd5, OP_LDB = 3'd6;

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] nxt  [NREG];
  logic [DATA_W-1:0] sel_mask, gen_data;
  logic [ADDR_W-1:0] gen_addr;
  logic              gen_we;

  assign sel_mask = DATA_W'(1) << bidx;
  assign stat_o   = regs[STAT];
  assign bit_o    = regs[addr][bidx];
  assign gen_we   = (op == OP_WR) || (op == OP_CLR) || (op == OP_SET) || (op == OP_STB);
  assign gen_addr = (op == OP_STB) ? STAT : addr;

  always_comb begin
    case (op)
      OP_CLR:  gen_data = din & ~sel_mask;
      OP_SET:  gen_data = din | sel_mask;
      OP_STB: begin
        gen_data = regs[STAT];
        gen_data[TBIT] = din[bidx];
      end
      default: gen_data = din;
    endcase
  end

  always_comb begin
    case (op)
      OP_RD:   dout = regs[addr];
      OP_LDB:  dout = (din & ~sel_mask) | (regs[STAT][TBIT] ? sel_mask : '0);
      default: dout = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      nxt[i] = regs[i];
      if (gen_we && gen_addr == ADDR_W'(i)) nxt[i] = gen_data;
    end
    for (int k = 0; k < NDED; k++)
      if (ded_we[k]) nxt[NREG-1-k] = ded_di[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (srst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
    end
  end

  for (genvar k = 0; k < NDED; k++) begin : g_ded
    assign ded_q[k*DATA_W +: DATA_W] = regs[NREG-1-k];
  end

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) srst |=> stat_o == '0 && ded_q == '0); // R1
  AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (op == OP_WR && ded_we == '0) |=> regs[$past(addr)] == $past(din)); // R2
  AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_RD && op != OP_LDB) |-> dout == '0); // R3
  AST_CLR_BIT: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (op == OP_CLR && ded_we == '0) |=> !regs[$past(addr)][$past(bidx)]); // R4
  AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (op == OP_SET && ded_we == '0) |=> regs[$past(addr)][$past(bidx)]); // R5
  AST_STB_T: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (op == OP_STB && !ded_we[0]) |=> stat_o[TBIT] == $past(din[bidx])); // R6
  AST_LDB_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LDB |-> $countones(dout ^ din) <= 1); // R7
  AST_DED_WINS: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ded_we[0] |=> stat_o == $past(ded_di[DATA_W-1:0])); // R9
  AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ((op == 3'd0 || op == 3'd7) && ded_we == '0) |=> $stable(ded_q)); // R11
endmodule

// File: tb/sim_ioreg_bitport.sv
module sim_ioreg_bitport;
  logic clk = 0, rst_n = 0, srst = 0;
  logic [2:0] op = 0;
  logic [5:0] addr = 0;
  logic [2:0] bidx = 0;
  logic [7:0] din = 0, dout, stat_o;
  logic bit_o;
  logic [7:0] ded_we = 0;
  logic [63:0] ded_di = 0, ded_q;
  logic [7:0] model [64];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ioreg_bitport u0 (.clk, .rst_n, .srst, .op, .addr, .bidx, .din, .dout,
                    .bit_o, .stat_o, .ded_we, .ded_di, .ded_q);

  function automatic logic [7:0] exp_dout();
    logic [7:0] v = din;
    if (op == 3'd2) return model[addr];
    if (op == 3'd6) begin v[bidx] = model[63][6]; return v; end
    return 8'h00;
  endfunction

  function automatic string op_tag();
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h op=%0d addr=%0d", tag, act, exp, op, addr);
    end
  endtask

  task automatic update_model();
    logic [7:0] v;
    bit coll = 0;
    if (srst) begin
      for (int i = 0; i < 64; i++) model[i] = 8'h00;
      return;
    end
    case (op)
      3'd1: model[addr] = din;
      3'd3: begin v = din; v[bidx] = 1'b0; model[addr] = v; end
      3'd4: begin v = din; v[bidx] = 1'b1; model[addr] = v; end
      3'd5: model[63][6] = din[bidx];
      default: ;
    endcase
    for (int k = 0; k < 8; k++)
      if (ded_we[k]) model[63-k] = ded_di[k*8 +: 8];
    coll = coll;
  endtask

  task automatic step();
    logic [63:0] expq;
    string tagq;
    #1;
    check(op_tag(), {56'd0, dout}, {56'd0, exp_dout()});
    check("R10", {63'd0, bit_o}, {63'd0, model[addr][bidx]});
    tagq = "R8";
    if (ded_we != 0 && (op == 3'd5 ? ded_we[0] :
        ((op == 3'd1 || op == 3'd3 || op == 3'd4) && addr >= 56 && ded_we[63-addr])))
      tagq = "R9";
    if (op == 3'd0 || op == 3'd7) tagq = "R11";
    @(posedge clk);
    update_model();
    @(negedge clk);
    for (int k = 0; k < 8; k++) expq[k*8 +: 8] = model[63-k];
    check(srst ? "R1" : tagq, ded_q, expq);
    check(srst ? "R1" : "R8", {56'd0, stat_o}, {56'd0, model[63]});
  endtask

  task automatic idle();
    op = 0; ded_we = 0; srst = 0; din = 0;
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 64; a++) begin
      idle(); op = 3'd2; addr = 6'(a);
      #1; check(tag, {56'd0, dout}, {56'd0, model[a]});
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", ded_q, 64'd0);
    sweep("R1");

    idle(); op = 3'd1; addr = 6'd10; din = 8'hC5; step();
    idle(); op = 3'd3; addr = 6'd10; din = model[10]; bidx = 3'd2; step();
    idle(); op = 3'd4; addr = 6'd10; din = model[10]; bidx = 3'd3; step();
    idle(); op = 3'd2; addr = 6'd10; step();
    check("R4", {56'd0, model[10]}, 64'hC9);
    idle(); op = 3'd5; din = 8'h93; bidx = 3'd4; step();
    idle(); op = 3'd6; din = 8'h93; bidx = 3'd5; step();
    idle(); op = 3'd1; addr = 6'd63; din = 8'h55; ded_we = 8'h01; ded_di = 64'hAA; step();
    idle(); op = 3'd5; din = 8'hFF; bidx = 3'd0; ded_we = 8'h01; ded_di = 64'h00; step();
    idle(); op = 3'd7; addr = 6'd63; din = 8'hFF; step();
    idle(); op = 3'd0; addr = 6'd5; din = 8'hFF; step();

    for (int n = 0; n < 4000; n++) begin
      idle();
      op = 3'($urandom_range(0, 7));
      addr = ($urandom_range(0, 1) == 1) ? 6'($urandom_range(56, 63)) : 6'($urandom_range(0, 63));
      bidx = 3'($urandom_range(0, 7));
      din = ($urandom_range(0, 1) == 1) ? model[addr] : 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        ded_we = 8'($urandom);
        ded_di = {$urandom, $urandom};
      end
      if (n == 2000) srst = 1;
      step();
      if (n == 2000) sweep("R1");
    end
    sweep("R2");

    rst_n = 0; #1;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    check("R1", ded_q, 64'd0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    sweep("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule